// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Sequencer

This block is the digital control side of an eight-channel successive-approximation analog-to-digital converter. It picks the analog channel, opens and closes the sample-and-hold switch, and drives a trial code to an external DAC. It then reads an external comparator bit by bit to build the result at 8-bit or 10-bit resolution. Each finished result is stored with the number of the channel it came from, and an interrupt flag is raised. Software sets it up through four word-wide registers: control, timing, status and data.

A conversion run starts from one of three activation sources: a software start bit, a rising edge of a reload-timer output, or a rising edge of a free-running timer's zero-detect signal. The control register picks a lowest and a highest channel. When they are equal the block converts a single channel. Otherwise it scans upward from the lowest channel to the highest. In one-shot mode every channel of the range is converted once. Continuous mode keeps cycling until software stops it. Incremental mode converts one channel per activation and halts after the last one. When interrupts are enabled, a new result is held back while the previous result's flag is still pending, so no unread result is ever overwritten.

The sequencer has four states. SQ_IDLE takes an activation (*start*) into SQ_CONV. SQ_CONV, at the end of a conversion, either moves into SQ_HOLD (*protect*) or *advances*. SQ_HOLD releases when the flag is cleared, then *advances*. SQ_PAUSE (incremental only) goes back to SQ_CONV on the next activation. An *advance* goes to SQ_IDLE, SQ_CONV or SQ_PAUSE according to the mode and whether the current channel is the last of the range. A stop request takes any state to SQ_IDLE. The bit-search engine has its own four states. SR_IDLE leaves on *start*. SR_SAMP runs for the sampling time, then passes to SR_TRIAL. SR_TRIAL repeats once per bit, then passes to SR_DONE. SR_DONE lasts one cycle, then returns to SR_IDLE, or goes straight back to SR_SAMP on a new start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the status register (address 2), the data register (address 3), `irq`, `sh_ctrl` and `ch_sel` all read 0.
- R2: In 10-bit mode (control bit 10 = 1) the result in data bits [9:0] is the largest code for which the comparator reports input >= `dac_code`. With `cmp_in` = (V >= `dac_code`), the result equals V, including V = 0 and V = 1023.
- R3: In 8-bit mode (control bit 10 = 0) the search runs over 8 bits only. The result is right-aligned in data bits [7:0], and data bits [9:8] read 0.
- R4: A one-shot run on a single channel (control mode bits [7:6] = 0, low channel [2:0] equal to high channel [5:3]) converts once, then clears busy (status bit 0). An activation that arrives while busy in one-shot or continuous mode is ignored.
- R5: In a one-shot scan (low < high), each channel from low up to high is converted once, in ascending order. Each result carries its channel number in data bits [12:10]. A high channel below the low channel is treated as equal to it.
- R6: In continuous mode (mode = 1) the range is converted repeatedly, wrapping from high back to low. Writing control bit 13 (stop) returns the block to idle at once, without writing a further result.
- R7: In incremental mode (mode = 2) each activation converts one channel. Between activations busy stays 1 and status bits [3:1] show the next channel. After the high channel, busy clears, and the next activation starts again at the low channel.
- R8: Control bits [9:8] select the activation source: 0 = control bit 12 written as 1, 1 = rising edge of `tmr_reload`, 2 = rising edge of `tmr_zero`. Activations from an unselected source are ignored.
- R9: Each stored result sets the flag in status bit 4. `irq` equals that flag ANDed with the enable in control bit 11. Writing the status register with bit 4 = 0 clears the flag.
- R10: With interrupts enabled, a conversion that ends while the flag is set is held. The data register keeps the old result and status bit 5 reads 1 until the flag is cleared. The held result is then stored and the flag is set again.
- R11: The sample phase (`sh_ctrl` = 1) lasts max(timing bits [7:0], 32) clock cycles. `ch_sel` does not change while sampling is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 timing, 2 status, 3 data |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from `reg_addr`) |
| tmr_reload | input | 1 | Reload-timer output; rising edge is an activation |
| tmr_zero | input | 1 | Free-running timer zero-detect; rising edge is an activation |
| cmp_in | input | 1 | Comparator: 1 when analog input >= DAC trial level |
| ch_sel | output | 3 | Analog channel select |
| sh_ctrl | output | 1 | Sample-and-hold switch, 1 while sampling |
| dac_code | output | 10 | Trial code to the DAC, right-aligned at the chosen resolution |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
A wrong bit-trial pointer or a missed clear of a trial bit shows up as a wrong data value at the end of that same conversion, some 50 cycles after activation with the bench's timing settings. A wrong sequencer state appears at the status register within one conversion: an extra run, a wrong channel tag in the data register, or busy in the wrong level. The protect path is checked while the flag is still pending. A lost hold overwrites the data register in the very cycle the second conversion ends, and a stuck hold leaves status bit 5 at 1 after the flag is cleared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_CONV  = 2'd1,
        SQ_HOLD  = 2'd2,
        SQ_PAUSE = 2'd3
    } seq_st_t;

    typedef enum logic [1:0] {
        SR_IDLE  = 2'd0,
        SR_SAMP  = 2'd1,
        SR_TRIAL = 2'd2,
        SR_DONE  = 2'd3
    } sar_st_t;

    typedef enum logic [1:0] {
        MD_ONCE = 2'd0,
        MD_CONT = 2'd1,
        MD_INCR = 2'd2,
        MD_RSVD = 2'd3
    } run_mode_t;

    localparam logic [1:0] SRC_SW     = 2'd0;
    localparam logic [1:0] SRC_RELOAD = 2'd1;
    localparam logic [1:0] SRC_FREE   = 2'd2;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_TIME = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int NTMR = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src,
    input  logic            sw_start,
    input  logic [NTMR-1:0] tmr_in,
    output logic            act
);

    logic [NTMR-1:0] prev_q;
    logic [NTMR-1:0] rise;

    // one edge detector per timer input; reset high so a line already high is no edge
    for (genvar g = 0; g < NTMR; g++) begin : g_edge
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q[g] <= 1'b1;
            end else begin
                prev_q[g] <= tmr_in[g];
            end
        end
        assign rise[g] = tmr_in[g] & ~prev_q[g];
    end

    always_comb begin
        case (src)
            SRC_SW:     act = sw_start;
            SRC_RELOAD: act = rise[0];
            SRC_FREE:   act = rise[NTMR-1];
            default:    act = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int RMAX     = 10,
    parameter int RLOW     = 8,
    parameter int CNTW     = 8,
    parameter int SAMP_MIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic            res_hi,
    input  logic [CNTW-1:0] samp_len,
    input  logic [CNTW-1:0] cmp_len,
    input  logic            cmp_in,
    output logic            sh,
    output logic [RMAX-1:0] code,
    output logic            res_lat,
    output logic            done,
    output logic            busy
);

    localparam int BPW = $clog2(RMAX);
    localparam logic [CNTW-1:0] SMIN = CNTW'(SAMP_MIN);
    localparam logic [BPW-1:0]  MSB_HI = BPW'(RMAX - 1);
    localparam logic [BPW-1:0]  MSB_LO = BPW'(RLOW - 1);

    sar_st_t          st;
    logic [CNTW-1:0]  cnt;
    logic [BPW-1:0]   bitp;
    logic [RMAX-1:0]  code_q;
    logic             res_q;
    logic [CNTW-1:0]  samp_eff;
    logic [CNTW-1:0]  cmp_eff;
    logic [BPW-1:0]   msb;

    assign samp_eff = (samp_len < SMIN) ? SMIN : samp_len;
    assign cmp_eff  = (cmp_len == '0) ? CNTW'(1) : cmp_len;
    assign msb      = res_q ? MSB_HI : MSB_LO;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= SR_IDLE;
            cnt    <= '0;
            bitp   <= '0;
            code_q <= '0;
            res_q  <= 1'b1;
        end else if (abort) begin
            st     <= SR_IDLE;
            code_q <= '0;
        end else begin
            unique case (st)
                SR_IDLE, SR_DONE: begin
                    if (start) begin
                        st     <= SR_SAMP;
                        cnt    <= samp_eff - CNTW'(1);
                        code_q <= '0;
                        res_q  <= res_hi;
                    end else begin
                        st <= SR_IDLE;
                    end
                end
                SR_SAMP: begin
                    if (cnt == '0) begin
                        st           <= SR_TRIAL;
                        bitp         <= msb;
                        code_q[msb]  <= 1'b1;
                        cnt          <= cmp_eff - CNTW'(1);
                    end else begin
                        cnt <= cnt - CNTW'(1);
                    end
                end
                SR_TRIAL: begin
                    if (cnt == '0) begin
                        if (!cmp_in) begin
                            code_q[bitp] <= 1'b0;
                        end
                        if (bitp == '0) begin
                            st <= SR_DONE;
                        end else begin
                            bitp                     <= bitp - BPW'(1);
                            code_q[bitp - BPW'(1)]   <= 1'b1;
                            cnt                      <= cmp_eff - CNTW'(1);
                        end
                    end else begin
                        cnt <= cnt - CNTW'(1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sh      = (st == SR_SAMP);
        done    = (st == SR_DONE);
        busy    = (st != SR_IDLE);
        code    = code_q;
        res_lat = res_q;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NCH      = 8,
    parameter int RMAX     = 10,
    parameter int RLOW     = 8,
    parameter int CNTW     = 8,
    parameter int SAMP_MIN = 32,
    parameter int DW       = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [1:0]               reg_addr,
    input  logic [DW-1:0]            reg_wdata,
    output logic [DW-1:0]            reg_rdata,
    input  logic                     tmr_reload,
    input  logic                     tmr_zero,
    input  logic                     cmp_in,
    output logic [$clog2(NCH)-1:0]   ch_sel,
    output logic                     sh_ctrl,
    output logic [RMAX-1:0]          dac_code,
    output logic                     irq
);

    localparam int CHW    = $clog2(NCH);
    localparam int O_LO   = 0;
    localparam int O_HI   = CHW;
    localparam int O_MD   = 2 * CHW;
    localparam int O_SRC  = 2 * CHW + 2;
    localparam int O_RES  = 2 * CHW + 4;
    localparam int O_IEN  = 2 * CHW + 5;
    localparam int O_GO   = 2 * CHW + 6;
    localparam int O_STOP = 2 * CHW + 7;
    localparam int S_BUSY = 0;
    localparam int S_CH   = 1;
    localparam int S_FLAG = CHW + 1;
    localparam int S_HELD = CHW + 2;

    // configuration
    logic [CHW-1:0]  cfg_lo, cfg_hi;
    run_mode_t       cfg_mode;
    logic [1:0]      cfg_src;
    logic            cfg_res, cfg_ien;
    logic [CNTW-1:0] t_samp, t_cmp;

    // sequencer state and result storage
    seq_st_t         seq_st;
    logic [CHW-1:0]  ch_ptr;
    logic [RMAX-1:0] data_val;
    logic [CHW-1:0]  data_ch;
    logic            flag_q;

    // internal nets
    logic            wr_ctrl, sw_go, stop_p, flag_clr;
    logic            act, act_ok, protect, write_now, busy;
    logic            core_start, core_done, core_busy, res_lat;
    logic [RMAX-1:0] core_code;
    logic [CHW-1:0]  hi_eff, nxt_ch, adv_ch;
    seq_st_t         adv_st;
    logic            adv_go, last_ch;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign sw_go    = wr_ctrl && reg_wdata[O_GO];
    assign stop_p   = wr_ctrl && reg_wdata[O_STOP];
    assign flag_clr = reg_wr && (reg_addr == A_STAT) && !reg_wdata[S_FLAG];

    adc_trig_sel #(.NTMR(2)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (cfg_src),
        .sw_start (sw_go),
        .tmr_in   ({tmr_zero, tmr_reload}),
        .act      (act)
    );

    adc_sar_core #(
        .RMAX(RMAX), .RLOW(RLOW), .CNTW(CNTW), .SAMP_MIN(SAMP_MIN)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (core_start),
        .abort    (stop_p),
        .res_hi   (cfg_res),
        .samp_len (t_samp),
        .cmp_len  (t_cmp),
        .cmp_in   (cmp_in),
        .sh       (sh_ctrl),
        .code     (core_code),
        .res_lat  (res_lat),
        .done     (core_done),
        .busy     (core_busy)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_lo   <= '0;
            cfg_hi   <= '0;
            cfg_mode <= MD_ONCE;
            cfg_src  <= SRC_SW;
            cfg_res  <= 1'b1;
            cfg_ien  <= 1'b0;
            t_samp   <= '0;
            t_cmp    <= CNTW'(1);
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                cfg_lo   <= reg_wdata[O_LO +: CHW];
                cfg_hi   <= reg_wdata[O_HI +: CHW];
                cfg_mode <= run_mode_t'(reg_wdata[O_MD +: 2]);
                cfg_src  <= reg_wdata[O_SRC +: 2];
                cfg_res  <= reg_wdata[O_RES];
                cfg_ien  <= reg_wdata[O_IEN];
            end else if (reg_addr == A_TIME) begin
                t_samp <= reg_wdata[0 +: CNTW];
                t_cmp  <= reg_wdata[CNTW +: CNTW];
            end
        end
    end

    // next step after a stored result, by mode and position in the range
    always_comb begin
        hi_eff  = (cfg_hi < cfg_lo) ? cfg_lo : cfg_hi;
        last_ch = (ch_ptr == hi_eff);
        nxt_ch  = ch_ptr + CHW'(1);
        case (cfg_mode)
            MD_CONT: begin
                adv_st = SQ_CONV;
                adv_ch = last_ch ? cfg_lo : nxt_ch;
                adv_go = 1'b1;
            end
            MD_INCR: begin
                adv_st = last_ch ? SQ_IDLE : SQ_PAUSE;
                adv_ch = last_ch ? cfg_lo : nxt_ch;
                adv_go = 1'b0;
            end
            default: begin
                adv_st = last_ch ? SQ_IDLE : SQ_CONV;
                adv_ch = last_ch ? ch_ptr : nxt_ch;
                adv_go = !last_ch;
            end
        endcase
    end

    // sequencer outputs
    always_comb begin
        busy      = (seq_st != SQ_IDLE);
        act_ok    = act && ((seq_st == SQ_IDLE) || (seq_st == SQ_PAUSE));
        protect   = cfg_ien && flag_q;
        write_now = ((seq_st == SQ_CONV) && core_done && !protect)
                 || ((seq_st == SQ_HOLD) && !flag_q);
        core_start = !stop_p && (act_ok || (write_now && adv_go));
        ch_sel     = ch_ptr;
        dac_code   = core_code;
        irq        = flag_q && cfg_ien;
    end

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_st <= SQ_IDLE;
            ch_ptr <= '0;
        end else if (stop_p) begin
            seq_st <= SQ_IDLE;
        end else begin
            unique case (seq_st)
                SQ_IDLE: begin
                    if (act) begin
                        seq_st <= SQ_CONV;
                        ch_ptr <= cfg_lo;
                    end
                end
                SQ_CONV: begin
                    if (core_done) begin
                        if (protect) begin
                            seq_st <= SQ_HOLD;
                        end else begin
                            seq_st <= adv_st;
                            ch_ptr <= adv_ch;
                        end
                    end
                end
                SQ_HOLD: begin
                    if (!flag_q) begin
                        seq_st <= adv_st;
                        ch_ptr <= adv_ch;
                    end
                end
                SQ_PAUSE: begin
                    if (act) begin
                        seq_st <= SQ_CONV;
                    end
                end
            endcase
        end
    end

    // result storage and completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_val <= '0;
            data_ch  <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (write_now && !stop_p) begin
                data_val <= core_code;
                data_ch  <= ch_ptr;
                flag_q   <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    // register read
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[O_LO +: CHW] = cfg_lo;
                reg_rdata[O_HI +: CHW] = cfg_hi;
                reg_rdata[O_MD +: 2]   = cfg_mode;
                reg_rdata[O_SRC +: 2]  = cfg_src;
                reg_rdata[O_RES]       = cfg_res;
                reg_rdata[O_IEN]       = cfg_ien;
            end
            A_TIME: begin
                reg_rdata[0 +: CNTW]    = t_samp;
                reg_rdata[CNTW +: CNTW] = t_cmp;
            end
            A_STAT: begin
                reg_rdata[S_BUSY]      = busy;
                reg_rdata[S_CH +: CHW] = ch_ptr;
                reg_rdata[S_FLAG]      = flag_q;
                reg_rdata[S_HELD]      = (seq_st == SQ_HOLD);
            end
            default: begin
                reg_rdata[0 +: RMAX]   = data_val;
                reg_rdata[RMAX +: CHW] = data_ch;
            end
        endcase
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int CHW      = 3,
    parameter int RMAX     = 10,
    parameter int RLOW     = 8,
    parameter int SAMP_MIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sh_ctrl,
    input logic [CHW-1:0]  ch_sel,
    input logic            irq,
    input logic            cfg_ien,
    input seq_st_t         seq_st,
    input logic [RMAX-1:0] data_val,
    input logic [RMAX-1:0] dac_code,
    input logic            res_lat,
    input logic            core_busy
);

    logic [8:0] sh_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_run <= '0;
        end else if (sh_ctrl) begin
            if (sh_run != 9'h1FF) sh_run <= sh_run + 9'd1;
        end else begin
            sh_run <= '0;
        end
    end

    // R11: a sample phase that ran to completion was at least the minimum length
    a_r11_samp_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sh_ctrl) && core_busy) |-> (sh_run >= 9'(SAMP_MIN)));

    // R11: channel select holds still through the sample phase
    a_r11_ch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_ctrl && $past(sh_ctrl)) |-> $stable(ch_sel));

    // R9: no interrupt request while interrupts are disabled
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg_ien);

    // R10: the data register does not move while a result is held back
    a_r10_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_st == SQ_HOLD) && $past(seq_st == SQ_HOLD)) |-> $stable(data_val));

    // R3: an 8-bit search never drives the upper trial bits
    a_r3_dac_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (core_busy && !res_lat) |-> (dac_code[RMAX-1:RLOW] == '0));

    // R4: sampling only happens inside a sequencer run
    a_r4_sh_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sh_ctrl |-> (seq_st == SQ_CONV));

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .CHW(CHW), .RMAX(RMAX), .RLOW(RLOW), .SAMP_MIN(SAMP_MIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_ctrl   (sh_ctrl),
    .ch_sel    (ch_sel),
    .irq       (irq),
    .cfg_ien   (cfg_ien),
    .seq_st    (seq_st),
    .data_val  (data_val),
    .dac_code  (dac_code),
    .res_lat   (res_lat),
    .core_busy (core_busy)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        tmr_reload = 1'b0;
    logic        tmr_zero = 1'b0;
    logic        cmp_in;
    logic [2:0]  ch_sel;
    logic        sh_ctrl;
    logic [9:0]  dac_code;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // analog model
    logic       m_res10 = 1'b1;
    logic       ovr_en = 1'b0;
    logic [9:0] ovr_val = 10'd0;
    logic [9:0] model_val;

    always #5 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_reload(tmr_reload),
        .tmr_zero(tmr_zero), .cmp_in(cmp_in), .ch_sel(ch_sel), .sh_ctrl(sh_ctrl),
        .dac_code(dac_code), .irq(irq)
    );

    function automatic int v10(int ch); return ch * 113 + 37; endfunction
    function automatic int v8(int ch);  return ch * 29 + 11;  endfunction

    always_comb begin
        if (ovr_en) model_val = ovr_val;
        else if (m_res10) model_val = 10'(v10(int'(ch_sel)));
        else model_val = 10'(v8(int'(ch_sel)));
        cmp_in = (model_val >= dac_code);
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [15:0] mk(int lo, int hi, int md, int src, bit r10, bit ien, bit go, bit stp);
        return 16'((lo & 7) | ((hi & 7) << 3) | ((md & 3) << 6) | ((src & 3) << 8)
                   | (int'(r10) << 10) | (int'(ien) << 11) | (int'(go) << 12) | (int'(stp) << 13));
    endfunction

    task automatic run(int lo, int hi, int md, int src, bit r10, bit ien);
        m_res10 = r10;
        wr(2'd0, mk(lo, hi, md, src, r10, ien, 1'b0, 1'b0));
        wr(2'd0, mk(lo, hi, md, src, r10, ien, 1'b1, 1'b0));
    endtask

    task automatic wait_stat(int bitn, bit val, input string tag);
        logic [15:0] s;
        bit seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(2'd2, s);
            if (s[bitn] == val) begin seen = 1'b1; break; end
        end
        if (!seen) chk(1'b0, tag, int'(!val), int'(val));
    endtask

    task automatic clr_flag();
        wr(2'd2, 16'd0);
    endtask

    task automatic chk_data(int ch, int val, input string tag);
        logic [15:0] d;
        rd(2'd3, d);
        chk(d[9:0] == 10'(val), {tag, " value"}, int'(d[9:0]), val);
        chk(d[12:10] == 3'(ch), {tag, " channel"}, int'(d[12:10]), ch);
    endtask

    task automatic t_reset();
        logic [15:0] s;
        rd(2'd2, s); chk(s == 16'd0, "R1 status", int'(s), 0);
        rd(2'd3, s); chk(s == 16'd0, "R1 data", int'(s), 0);
        chk(irq == 1'b0 && sh_ctrl == 1'b0, "R1 irq/sh", int'({irq, sh_ctrl}), 0);
        chk(ch_sel == 3'd0, "R1 ch_sel", int'(ch_sel), 0);
    endtask

    task automatic t_single10();
        logic [15:0] s;
        run(3, 3, 0, 0, 1'b1, 1'b1);
        wait_stat(4, 1'b1, "R9 flag set");
        chk_data(3, v10(3), "R2 ch3");
        chk(irq == 1'b1, "R9 irq high", int'(irq), 1);
        wait_stat(0, 1'b0, "R4 busy clears");
        clr_flag();
        #1;
        chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
        rd(2'd2, s); chk(s[4] == 1'b0, "R9 flag cleared", int'(s[4]), 0);
    endtask

    task automatic t_bounds();
        ovr_en = 1'b1;
        ovr_val = 10'd1023;
        run(0, 0, 0, 0, 1'b1, 1'b0);
        wait_stat(4, 1'b1, "R2 max done");
        chk_data(0, 1023, "R2 full scale");
        clr_flag();
        ovr_val = 10'd0;
        run(0, 0, 0, 0, 1'b1, 1'b0);
        wait_stat(4, 1'b1, "R2 zero done");
        chk_data(0, 0, "R2 zero scale");
        clr_flag();
        ovr_en = 1'b0;
    endtask

    task automatic t_8bit();
        logic [15:0] d;
        run(5, 5, 0, 0, 1'b0, 1'b1);
        wait_stat(4, 1'b1, "R3 done");
        chk_data(5, v8(5), "R3 ch5 8-bit");
        clr_flag();
        ovr_en = 1'b1; ovr_val = 10'd1023;
        run(5, 5, 0, 0, 1'b0, 1'b1);
        wait_stat(4, 1'b1, "R3 done max");
        rd(2'd3, d);
        chk(d[9:0] == 10'd255, "R3 right aligned, upper zero", int'(d[9:0]), 255);
        clr_flag();
        ovr_en = 1'b0;
    endtask

    task automatic t_ignore();
        logic [15:0] s;
        run(1, 1, 0, 0, 1'b1, 1'b1);
        wr(2'd0, mk(1, 1, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0));
        wait_stat(4, 1'b1, "R4 first done");
        wait_stat(0, 1'b0, "R4 idle");
        clr_flag();
        repeat (400) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0 && s[0] == 1'b0, "R4 busy trigger ignored", int'(s[5:0]), 0);
    endtask

    task automatic t_samp(int field, int expn);
        int n = 0;
        wr(2'd1, 16'((2 << 8) | field));
        run(2, 2, 0, 0, 1'b1, 1'b0);
        for (int i = 0; i < 200 && !sh_ctrl; i++) @(negedge clk);
        while (sh_ctrl && n < 1000) begin n++; @(negedge clk); end
        chk(n == expn, "R11 sample length", n, expn);
        wait_stat(0, 1'b0, "R11 idle");
        clr_flag();
    endtask

    task automatic t_scan_once();
        run(6, 7, 0, 0, 1'b1, 1'b1);
        wait_stat(4, 1'b1, "R5 first");
        chk_data(6, v10(6), "R5 scan first");
        clr_flag();
        wait_stat(4, 1'b1, "R5 second");
        chk_data(7, v10(7), "R5 scan second");
        wait_stat(0, 1'b0, "R5 idle");
        clr_flag();
        run(4, 2, 0, 0, 1'b1, 1'b1);
        wait_stat(4, 1'b1, "R5 reversed");
        wait_stat(0, 1'b0, "R5 reversed idle");
        chk_data(4, v10(4), "R5 high below low");
        clr_flag();
    endtask

    task automatic t_protect();
        logic [15:0] s;
        run(2, 3, 0, 0, 1'b1, 1'b1);
        wait_stat(4, 1'b1, "R10 first");
        wait_stat(5, 1'b1, "R10 held");
        chk_data(2, v10(2), "R10 old result kept");
        clr_flag();
        repeat (3) @(negedge clk);
        chk_data(3, v10(3), "R10 released result");
        rd(2'd2, s);
        chk(s[4] == 1'b1 && s[5] == 1'b0, "R10 flag again, not held", int'(s[5:4]), 1);
        clr_flag();
        wait_stat(0, 1'b0, "R10 idle");
    endtask

    task automatic t_cont();
        logic [15:0] s;
        run(0, 1, 1, 0, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            wait_stat(4, 1'b1, "R6 result");
            chk_data(k % 2, v10(k % 2), "R6 continuous order");
            clr_flag();
        end
        wr(2'd0, mk(0, 1, 1, 0, 1'b1, 1'b1, 1'b0, 1'b1));
        rd(2'd2, s);
        chk(s[0] == 1'b0, "R6 stop idles", int'(s[0]), 0);
        clr_flag();
        repeat (300) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0 && s[0] == 1'b0, "R6 nothing after stop", int'(s[4:0]), 0);
    endtask

    task automatic t_incr();
        logic [15:0] s;
        run(4, 6, 2, 0, 1'b1, 1'b1);
        wait_stat(4, 1'b1, "R7 first");
        chk_data(4, v10(4), "R7 step one");
        rd(2'd2, s);
        chk(s[0] == 1'b1 && s[3:1] == 3'd5, "R7 paused busy, next ch", int'(s[3:0]), 11);
        clr_flag();
        repeat (200) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0, "R7 waits for activation", int'(s[4]), 0);
        wr(2'd0, mk(4, 6, 2, 0, 1'b1, 1'b1, 1'b1, 1'b0));
        wait_stat(4, 1'b1, "R7 second");
        chk_data(5, v10(5), "R7 step two");
        clr_flag();
        wr(2'd0, mk(4, 6, 2, 0, 1'b1, 1'b1, 1'b1, 1'b0));
        wait_stat(4, 1'b1, "R7 third");
        chk_data(6, v10(6), "R7 step three");
        rd(2'd2, s);
        chk(s[0] == 1'b0, "R7 halts after last", int'(s[0]), 0);
        clr_flag();
        wr(2'd0, mk(4, 6, 2, 0, 1'b1, 1'b1, 1'b1, 1'b0));
        wait_stat(4, 1'b1, "R7 restart");
        chk_data(4, v10(4), "R7 restarts at low");
        clr_flag();
        wait_stat(0, 1'b1, "R7 paused");
        wr(2'd0, mk(4, 6, 2, 0, 1'b1, 1'b1, 1'b0, 1'b1));
    endtask

    task automatic pulse(input bit which);
        @(negedge clk);
        if (which) tmr_zero = 1'b1; else tmr_reload = 1'b1;
        repeat (3) @(negedge clk);
        tmr_zero = 1'b0; tmr_reload = 1'b0;
    endtask

    task automatic t_trig();
        logic [15:0] s;
        run(7, 7, 0, 1, 1'b1, 1'b1);
        pulse(1'b1);
        repeat (300) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0, "R8 sw and zero ignored when reload selected", int'(s[4]), 0);
        pulse(1'b0);
        wait_stat(4, 1'b1, "R8 reload start");
        chk_data(7, v10(7), "R8 reload edge");
        wait_stat(0, 1'b0, "R8 idle");
        clr_flag();
        wr(2'd0, mk(7, 7, 0, 2, 1'b1, 1'b1, 1'b0, 1'b0));
        pulse(1'b0);
        repeat (300) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0, "R8 reload ignored when zero selected", int'(s[4]), 0);
        pulse(1'b1);
        wait_stat(4, 1'b1, "R8 zero start");
        chk_data(7, v10(7), "R8 zero edge");
        wait_stat(0, 1'b0, "R8 idle 2");
        clr_flag();
        wr(2'd0, mk(7, 7, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0));
        pulse(1'b0); pulse(1'b1);
        repeat (300) @(negedge clk);
        rd(2'd2, s);
        chk(s[4] == 1'b0, "R8 timers ignored when software selected", int'(s[4]), 0);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        wr(2'd1, 16'((2 << 8) | 0));
        t_single10();
        t_bounds();
        t_8bit();
        t_ignore();
        t_samp(10, 32);
        t_samp(40, 40);
        wr(2'd1, 16'((2 << 8) | 0));
        t_scan_once();
        t_protect();
        t_cont();
        t_incr();
        t_trig();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule